// File: doc/BRIEF.md
# Single-Precision Float to Integer Saturating Converter

This block turns a single-precision IEEE-754 bit pattern into a 32-bit or 64-bit integer, signed or unsigned. The integer is always delivered in a 64-bit destination. A narrow result is sign-extended from its bit 31. A rounding-mode field decides how fractional values are resolved. Two sticky-style flags go with each result: invalid and inexact. The caller ORs these flags into its accrued exception state.

Every unusual input produces a defined integer. NaN, infinity, values that are too large and negative values sent to an unsigned target each have a fixed saturation value, and each of them raises invalid. The conversion has one registered stage. The inputs are sampled on a rising clock edge, and the result and flags are held from that edge until the next one.

Top module: `f2i_conv`

## Requirements
- R1: A synchronous active-high reset clears the result and both flags to zero. Outside reset, the outputs reflect the inputs sampled at the previous rising edge.
- R2: The target selector uses these codes: 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit. Every 32-bit result is sign-extended from bit 31 into the 64-bit output.
- R3: The rounding field uses these codes: 0 = nearest with ties to even, 1 = toward zero, 2 = toward minus infinity, 3 = toward plus infinity, 4 = nearest with ties away from zero. Codes 5 to 7 behave as toward zero.
- R4: For an input whose rounded value fits the target, the output is that exact integer and invalid is clear. Inexact is set exactly when nonzero fraction bits were discarded.
- R5: A NaN input of either sign raises invalid. A signed target then returns its largest positive value: 0x000000007FFFFFFF for 32-bit and 0x7FFFFFFFFFFFFFFF for 64-bit. An unsigned target returns all 64 bits set.
- R6: For a signed target, a rounded value above the target maximum returns the maximum. A rounded value below the minimum returns the minimum: 0xFFFFFFFF80000000 for 32-bit and 0x8000000000000000 for 64-bit. Both cases set invalid. The exact minimum converts without invalid.
- R7: For an unsigned target, a negative input that rounds to a nonzero magnitude returns zero and sets invalid. A negative input that rounds to zero returns zero without invalid, and inexact follows R4.
- R8: For an unsigned target, a rounded value above the target maximum returns all 64 bits set and raises invalid.
- R9: Positive infinity is treated as an overflow of the positive limit and negative infinity as an overflow of the negative limit, with the outputs of R6 and R8.
- R10: Invalid and inexact are never set together.
- R11: Zero of either sign gives 0 with no flags. A subnormal input gives 0, or 1 or -1 where the rounding mode moves it away from zero, and always sets inexact unless invalid applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_in | input | 32 | Single-precision operand bit pattern |
| sel_in | input | 2 | Target type code (R2) |
| rm_in | input | 3 | Rounding-mode code (R3) |
| res_out | output | 64 | Converted integer, registered |
| inv_out | output | 1 | Invalid-operation flag, registered |
| inx_out | output | 1 | Inexact flag, registered |

## Verification
Each of the three outputs is due exactly one rising edge after its operand, selector and rounding code are presented. A reset asserted before an edge clears them at that same edge. The bench drives a fresh vector on every falling edge. At the next falling edge, after exactly one rising edge, it compares the outputs with a behavioural model that was evaluated on the vector it just drove, so every clock is checked at the one cycle where its result is valid. The directed sweeps pass every boundary operand through all selector and rounding codes. Hand-written literals pin the saturation patterns. A randomized run covers exponents on both sides of the 32-bit and 64-bit limits.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  // Target type codes: bit 1 picks the wide target, bit 0 picks unsigned.
  typedef enum logic [1:0] {
    SEL_S32 = 2'd0,
    SEL_U32 = 2'd1,
    SEL_S64 = 2'd2,
    SEL_U64 = 2'd3
  } conv_sel_e;

  // Rounding codes; values 5..7 fall back to truncation.
  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_ZERO      = 3'd1,
    RM_DOWN      = 3'd2,
    RM_UP        = 3'd3,
    RM_NEAR_MAX  = 3'd4
  } rnd_mode_e;

  typedef struct packed {
    logic invalid;
    logic inexact;
  } flags_t;

endpackage

// File: rtl/f2i_unpack.sv
// Splits the operand into sign, class and a fixed-point magnitude:
// integer part plus one round bit and one sticky bit.
module f2i_unpack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int OUT_W = 64,
  localparam int FLT_W = EXP_W + MAN_W + 1
) (
  input  logic [FLT_W-1:0] op,
  output logic             neg,
  output logic             is_nan,
  output logic             is_huge,
  output logic [OUT_W-1:0] int_part,
  output logic             rnd_bit,
  output logic             sticky_bit
);

  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int SIG_W = MAN_W + 1;
  localparam int FIX_W = OUT_W + SIG_W;
  localparam int SH_W  = $clog2(OUT_W + 1);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max;
  logic             exp_zero;
  logic             man_zero;
  logic             tiny;
  logic             in_window;
  logic [SH_W-1:0]  sh;
  logic [FIX_W-1:0] fixed;
  int               unb;

  assign neg      = op[FLT_W-1];
  assign exp_f    = op[FLT_W-2:MAN_W];
  assign man_f    = op[MAN_W-1:0];
  assign exp_max  = &exp_f;
  assign exp_zero = ~|exp_f;
  assign man_zero = ~|man_f;
  assign is_nan   = exp_max & ~man_zero;

  always_comb begin
    unb       = int'(exp_f) - BIAS;
    // below one half: only the sticky information survives
    tiny      = !exp_max && (unb < -1);
    is_huge   = exp_max ? man_zero : (unb >= OUT_W);
    in_window = !exp_max && !tiny && (unb < OUT_W);
    sh        = in_window ? SH_W'(unb + 1) : '0;
    // hidden bit lands on the round position when the shift is zero
    fixed     = {{OUT_W{1'b0}}, 1'b1, man_f} << sh;
  end

  always_comb begin
    if (in_window) begin
      int_part   = fixed[FIX_W-1:SIG_W];
      rnd_bit    = fixed[SIG_W-1];
      sticky_bit = |fixed[SIG_W-2:0];
    end else begin
      int_part   = '0;
      rnd_bit    = 1'b0;
      sticky_bit = tiny & ~(exp_zero & man_zero);
    end
  end

endmodule

// File: rtl/f2i_round.sv
// Applies the rounding mode to the integer magnitude.
module f2i_round #(
  parameter int OUT_W = 64
) (
  input  logic [2:0]       rm,
  input  logic             neg,
  input  logic [OUT_W-1:0] int_part,
  input  logic             rnd_bit,
  input  logic             sticky_bit,
  output logic [OUT_W:0]   mag,
  output logic             lost
);

  import f2i_pkg::*;

  rnd_mode_e mode;
  logic      bump;

  assign mode = rnd_mode_e'(rm);
  assign lost = rnd_bit | sticky_bit;

  always_comb begin
    case (mode)
      RM_NEAR_EVEN: bump = rnd_bit & (sticky_bit | int_part[0]);
      RM_DOWN:      bump = neg & lost;
      RM_UP:        bump = ~neg & lost;
      RM_NEAR_MAX:  bump = rnd_bit;
      default:      bump = 1'b0;
    endcase
  end

  // one spare bit keeps a carry out of the top for the range check
  assign mag = {1'b0, int_part} + {{OUT_W{1'b0}}, bump};

endmodule

// File: rtl/f2i_saturate.sv
// Range check against the selected target and final result selection.
module f2i_saturate #(
  parameter int OUT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  logic [1:0]       sel,
  input  logic             neg,
  input  logic             is_nan,
  input  logic             is_huge,
  input  logic [OUT_W:0]   mag,
  input  logic             lost,
  output logic [OUT_W-1:0] value,
  output logic             invalid,
  output logic             inexact
);

  import f2i_pkg::*;

  localparam int PAD_W = OUT_W - NARROW_W + 1;
  localparam logic [OUT_W:0]   ONE    = {{OUT_W{1'b0}}, 1'b1};
  localparam logic [OUT_W-1:0] SMAX_N = {{PAD_W{1'b0}}, {(NARROW_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] SMIN_N = ~SMAX_N;
  localparam logic [OUT_W-1:0] SMAX_W = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] SMIN_W = ~SMAX_W;
  localparam logic [OUT_W:0]   LP_S_N = {1'b0, SMAX_N};
  localparam logic [OUT_W:0]   LN_S_N = LP_S_N + ONE;
  localparam logic [OUT_W:0]   LP_U_N = {{PAD_W{1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [OUT_W:0]   LP_S_W = {1'b0, SMAX_W};
  localparam logic [OUT_W:0]   LN_S_W = LP_S_W + ONE;
  localparam logic [OUT_W:0]   LP_U_W = {1'b0, {OUT_W{1'b1}}};

  conv_sel_e        kind;
  logic [OUT_W:0]   lim_pos;
  logic [OUT_W:0]   lim_neg;
  logic [OUT_W-1:0] sat_max;
  logic [OUT_W-1:0] sat_min;
  logic             uns;
  logic             over_pos;
  logic             over_neg;
  logic [OUT_W-1:0] twos;
  logic [OUT_W-1:0] narrow_val;

  assign kind = conv_sel_e'(sel);
  assign uns  = sel[0];

  always_comb begin
    case (kind)
      SEL_S32: begin lim_pos = LP_S_N; lim_neg = LN_S_N; sat_max = SMAX_N; sat_min = SMIN_N; end
      SEL_U32: begin lim_pos = LP_U_N; lim_neg = '0;     sat_max = '1;     sat_min = '0;     end
      SEL_S64: begin lim_pos = LP_S_W; lim_neg = LN_S_W; sat_max = SMAX_W; sat_min = SMIN_W; end
      default: begin lim_pos = LP_U_W; lim_neg = '0;     sat_max = '1;     sat_min = '0;     end
    endcase
  end

  assign over_pos = ~neg & (is_huge | (mag > lim_pos));
  assign over_neg =  neg & (is_huge | (mag > lim_neg));
  assign invalid  = is_nan | over_pos | over_neg;
  assign inexact  = lost & ~invalid;

  assign twos = neg ? (~mag[OUT_W-1:0] + {{(OUT_W-1){1'b0}}, 1'b1}) : mag[OUT_W-1:0];

  generate
    if (NARROW_W < OUT_W) begin : g_ext
      assign narrow_val = {{(OUT_W-NARROW_W){twos[NARROW_W-1]}}, twos[NARROW_W-1:0]};
    end else begin : g_flat
      assign narrow_val = twos;
    end
  endgenerate

  always_comb begin
    if (is_nan)        value = uns ? '1 : sat_max;
    else if (over_pos) value = sat_max;
    else if (over_neg) value = sat_min;
    else if (sel[1])   value = twos;
    else               value = narrow_val;
  end

endmodule

// File: rtl/f2i_conv.sv
// Top: unpack -> round -> saturate, one output register.
module f2i_conv #(
  parameter int EXP_W    = 8,
  parameter int MAN_W    = 23,
  parameter int OUT_W    = 64,
  parameter int NARROW_W = 32,
  localparam int FLT_W   = EXP_W + MAN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FLT_W-1:0] op_in,
  input  logic [1:0]       sel_in,
  input  logic [2:0]       rm_in,
  output logic [OUT_W-1:0] res_out,
  output logic             inv_out,
  output logic             inx_out
);

  import f2i_pkg::*;

  logic             neg;
  logic             is_nan;
  logic             is_huge;
  logic [OUT_W-1:0] int_part;
  logic             rnd_bit;
  logic             sticky_bit;
  logic [OUT_W:0]   mag;
  logic             lost;
  logic [OUT_W-1:0] value;
  flags_t           flg;

  f2i_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_W(OUT_W)) unpack_i (
    .op         (op_in),
    .neg        (neg),
    .is_nan     (is_nan),
    .is_huge    (is_huge),
    .int_part   (int_part),
    .rnd_bit    (rnd_bit),
    .sticky_bit (sticky_bit)
  );

  f2i_round #(.OUT_W(OUT_W)) round_i (
    .rm         (rm_in),
    .neg        (neg),
    .int_part   (int_part),
    .rnd_bit    (rnd_bit),
    .sticky_bit (sticky_bit),
    .mag        (mag),
    .lost       (lost)
  );

  f2i_saturate #(.OUT_W(OUT_W), .NARROW_W(NARROW_W)) sat_i (
    .sel        (sel_in),
    .neg        (neg),
    .is_nan     (is_nan),
    .is_huge    (is_huge),
    .mag        (mag),
    .lost       (lost),
    .value      (value),
    .invalid    (flg.invalid),
    .inexact    (flg.inexact)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out <= '0;
      inv_out <= 1'b0;
      inx_out <= 1'b0;
    end else begin
      res_out <= value;
      inv_out <= flg.invalid;
      inx_out <= flg.inexact;
    end
  end

endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk #(
  parameter int EXP_W    = 8,
  parameter int MAN_W    = 23,
  parameter int OUT_W    = 64,
  parameter int NARROW_W = 32,
  localparam int FLT_W   = EXP_W + MAN_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [FLT_W-1:0] op_in,
  input logic [1:0]       sel_in,
  input logic [OUT_W-1:0] res_out,
  input logic             inv_out,
  input logic             inx_out
);

  logic exp_all1;
  logic man_nz;
  logic op_nan;
  logic op_inf;

  assign exp_all1 = &op_in[FLT_W-2:MAN_W];
  assign man_nz   = |op_in[MAN_W-1:0];
  assign op_nan   = exp_all1 & man_nz;
  assign op_inf   = exp_all1 & ~man_nz;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (res_out == '0 && !inv_out && !inx_out));

  assert_narrow_signext_R2: assert property (@(posedge clk) disable iff (rst)
    !sel_in[1] |=> (&res_out[OUT_W-1:NARROW_W-1] || ~|res_out[OUT_W-1:NARROW_W-1]));

  assert_nan_invalid_R5: assert property (@(posedge clk) disable iff (rst)
    op_nan |=> inv_out);

  assert_unsigned_negative_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_in[0] && op_in[FLT_W-1] && !op_nan) |=> (res_out == '0));

  assert_infinity_invalid_R9: assert property (@(posedge clk) disable iff (rst)
    op_inf |=> inv_out);

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(inv_out && inx_out));

  assert_zero_exact_R11: assert property (@(posedge clk) disable iff (rst)
    (op_in[FLT_W-2:0] == '0) |=> (res_out == '0 && !inv_out && !inx_out));

endmodule

bind f2i_conv f2i_conv_chk #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_W(OUT_W), .NARROW_W(NARROW_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .op_in   (op_in),
  .sel_in  (sel_in),
  .res_out (res_out),
  .inv_out (inv_out),
  .inx_out (inx_out)
);

// File: tb/f2i_conv_tb_top.sv
`timescale 1ns/1ps
module f2i_conv_tb_top;

  logic        clk;
  logic        rst;
  logic [31:0] op_in;
  logic [1:0]  sel_in;
  logic [2:0]  rm_in;
  logic [63:0] res_out;
  logic        inv_out;
  logic        inx_out;

  int checks = 0;
  int errors = 0;

  f2i_conv dut_i (
    .clk(clk), .rst(rst), .op_in(op_in), .sel_in(sel_in), .rm_in(rm_in),
    .res_out(res_out), .inv_out(inv_out), .inx_out(inx_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural model: exact big-integer value, remainder compared with half.
  function automatic void ref_conv(input logic [31:0] op, input logic [1:0] sel,
                                   input logic [2:0] rm, output logic [63:0] r,
                                   output logic inv, output logic inx);
    logic [191:0] m, ip, rem, half, mag, lim_pos, lim_neg;
    logic [63:0]  v;
    int e, s;
    bit neg, up, wide, uns;
    neg = op[31]; wide = sel[1]; uns = sel[0];
    inv = 0; inx = 0; r = 0;
    if (op[30:23] == 8'hFF && op[22:0] != 0) begin
      inv = 1;
      r = uns ? 64'hFFFF_FFFF_FFFF_FFFF : (wide ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h7FFF_FFFF);
      return;
    end
    if (op[30:23] == 8'hFF) begin
      mag = 192'd1 << 130;
    end else begin
      if (op[30:23] == 0) begin m = 192'(op[22:0]); e = -126; end
      else begin m = 192'({1'b1, op[22:0]}); e = int'(op[30:23]) - 127; end
      if (e >= 23) begin
        mag = m << (e - 23);
      end else begin
        s = 23 - e;
        ip = m >> s;
        rem = m & ((192'd1 << s) - 192'd1);
        half = 192'd1 << (s - 1);
        case (rm)
          3'd0: up = (rem > half) || (rem == half && ip[0]);
          3'd2: up = neg && rem != 0;
          3'd3: up = !neg && rem != 0;
          3'd4: up = rem >= half;
          default: up = 0;
        endcase
        mag = ip + 192'(up);
        inx = rem != 0;
      end
    end
    if (uns) begin
      lim_pos = wide ? ((192'd1 << 64) - 1) : ((192'd1 << 32) - 1);
      lim_neg = 0;
    end else begin
      lim_pos = wide ? ((192'd1 << 63) - 1) : ((192'd1 << 31) - 1);
      lim_neg = wide ? (192'd1 << 63) : (192'd1 << 31);
    end
    if (!neg && mag > lim_pos) begin
      inv = 1; inx = 0;
      r = uns ? 64'hFFFF_FFFF_FFFF_FFFF : (wide ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h7FFF_FFFF);
    end else if (neg && mag > lim_neg) begin
      inv = 1; inx = 0;
      r = uns ? 64'h0 : (wide ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000);
    end else begin
      v = neg ? (64'h0 - mag[63:0]) : mag[63:0];
      if (!wide) v = {{32{v[31]}}, v[31:0]};
      r = v;
    end
  endfunction

  function automatic string tag_for(input logic [31:0] op, input logic [1:0] sel, input logic inv);
    if (op[30:23] == 8'hFF) return (op[22:0] != 0) ? "R5" : "R9";
    if (op[30:23] == 8'h00) return "R11";
    if (!inv) return sel[1] ? "R4" : "R2";
    if (!sel[0]) return "R6";
    return op[31] ? "R7" : "R8";
  endfunction

  task automatic compare(input string tag, input logic [63:0] er, input logic ei, input logic ex);
    checks++;
    if (res_out !== er || inv_out !== ei || inx_out !== ex) begin
      errors++;
      $display("FAIL %s: got res=%h inv=%b inx=%b, expected res=%h inv=%b inx=%b",
               tag, res_out, inv_out, inx_out, er, ei, ex);
    end
  endtask

  // Called at a falling edge; checks one rising edge later.
  task automatic drive_check(input logic [31:0] op, input logic [1:0] sel,
                             input logic [2:0] rm, input string tag);
    logic [63:0] er;
    logic ei, ex;
    string t;
    ref_conv(op, sel, rm, er, ei, ex);
    t = (tag == "") ? tag_for(op, sel, ei) : tag;
    op_in = op; sel_in = sel; rm_in = rm;
    @(negedge clk);
    compare(t, er, ei, ex);
  endtask

  task automatic drive_lit(input logic [31:0] op, input logic [1:0] sel, input logic [2:0] rm,
                           input logic [63:0] er, input logic ei, input logic ex, input string tag);
    op_in = op; sel_in = sel; rm_in = rm;
    @(negedge clk);
    compare(tag, er, ei, ex);
  endtask

  logic [31:0] sweep_ops [25] = '{
    32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'h8000_0001, 32'h3F00_0000,
    32'hBF00_0000, 32'h3F40_0000, 32'h3FC0_0000, 32'hBFC0_0000, 32'h4020_0000,
    32'hC020_0000, 32'h4F00_0000, 32'hCF00_0000, 32'h4F80_0000, 32'h4EFF_FFFF,
    32'h5F00_0000, 32'hDF00_0000, 32'h5F80_0000, 32'h5EFF_FFFF, 32'h7F80_0000,
    32'hFF80_0000, 32'h7FC0_0000, 32'hFFC0_0000, 32'h7F80_0001, 32'h4B7F_FFFF
  };

  initial begin
    rst = 1'b1; op_in = 32'h3F80_0000; sel_in = 2'd0; rm_in = 3'd0;
    repeat (3) @(negedge clk);
    compare("R1", 64'h0, 1'b0, 1'b0);   // R1 reset state
    rst = 1'b0;

    // R1: latency and mid-run reset
    drive_lit(32'h3F80_0000, 2'd2, 3'd0, 64'd1, 1'b0, 1'b0, "R1");
    rst = 1'b1;
    @(negedge clk);
    compare("R1", 64'h0, 1'b0, 1'b0);
    rst = 1'b0;

    // literal corner values
    drive_lit(32'h7FC0_0000, 2'd0, 3'd0, 64'h0000_0000_7FFF_FFFF, 1'b1, 1'b0, "R5");
    drive_lit(32'hFFC0_0000, 2'd1, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R5");
    drive_lit(32'hFF80_0000, 2'd0, 3'd0, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0, "R9");
    drive_lit(32'h4020_0000, 2'd2, 3'd0, 64'd2, 1'b0, 1'b1, "R3");
    drive_lit(32'h4020_0000, 2'd2, 3'd4, 64'd3, 1'b0, 1'b1, "R3");
    drive_lit(32'hC020_0000, 2'd0, 3'd2, 64'hFFFF_FFFF_FFFF_FFFD, 1'b0, 1'b1, "R3");
    drive_lit(32'h3FC0_0000, 2'd0, 3'd6, 64'd1, 1'b0, 1'b1, "R3");
    drive_lit(32'hBF00_0000, 2'd1, 3'd1, 64'd0, 1'b0, 1'b1, "R7");
    drive_lit(32'hBFC0_0000, 2'd3, 3'd0, 64'd0, 1'b1, 1'b0, "R7");
    drive_lit(32'h4F80_0000, 2'd1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R8");
    drive_lit(32'hCF00_0000, 2'd0, 3'd0, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0, "R6");
    drive_lit(32'h4F00_0000, 2'd0, 3'd0, 64'h0000_0000_7FFF_FFFF, 1'b1, 1'b0, "R6");
    drive_lit(32'h0000_0001, 2'd2, 3'd3, 64'd1, 1'b0, 1'b1, "R11");
    drive_lit(32'h4F32_D05E, 2'd1, 3'd0, 64'hFFFF_FFFF_B2D0_5E00, 1'b0, 1'b0, "R2");

    // directed sweep: every boundary operand through all targets and modes
    for (int k = 0; k < 25; k++)
      for (int sl = 0; sl < 4; sl++)
        for (int md = 0; md < 8; md++)
          drive_check(sweep_ops[k], 2'(sl), 3'(md), "");

    // randomized exponents around both width limits
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] ex;
      ex = 8'(100 + $urandom_range(0, 99));
      if (i % 16 == 0) ex = 8'hFF;
      if (i % 16 == 1) ex = 8'h00;
      drive_check({1'($urandom), ex, 23'($urandom)}, 2'($urandom), 3'($urandom_range(0, 7)), "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: run still active, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule